// File: doc/BRIEF.md
# Bitplane scroll delay shifter

This block turns fetched bitplane words into one pixel bit per plane per pixel clock, and it applies a programmable horizontal scroll. The planes form two groups. Group A is plane indices 0, 2, 4 and 6. Group B is plane indices 1, 3, 5 and 7. Each group has its own delay. When a whole block of plane words has been fetched, the words go into per-plane holding registers. Each group then waits until a running position counter equals that group's delay. At that point it moves its holding registers into its output shift registers. Because the two groups wait for different positions, one group can be scrolled against the other, down to a sub-pixel step.

A 16-bit scroll control word selects the delays. It is decoded according to the resolution code (0 = low, 1 = high, 2 = super-high) and the fetch width (16, 32 or 64 bits, set by a fetch-mode code of 0, 1 or 2). A new control word only takes effect at the next fetch-cycle boundary. The block sits between the bitplane fetch engine and the pixel/colour stage. The fetch engine drives the block-complete, line-start and boundary strobes. The pixel stage consumes `pixOut` on every cycle in which `pixEn` is high.

Top module: `bpl_scroll_shifter`

## Requirements
- R1: When `rst` is high at a clock edge, all holding registers, data registers, shift registers, both pending flags, the position counter and `pixOut` are cleared, so `pixOut` reads 0 after reset.
- R2: Group A uses coarse delay bits {ctl[11:10], ctl[3:0]} and fine bits ctl[13:12]. Group B uses coarse delay bits {ctl[15:14], ctl[7:4]} and fine bits ctl[9:8]. Each group's delay is ((coarse & (mask >> res)) << res) | (fine >> (2 − res)).
- R3: The fetch size is 16 << fetchMode bits and mask = size − 1. Coarse bits above the mask have no effect. The pixel output is taken from bit size − 1.
- R4: With resolution code 1 or 2, the coarse delay is scaled up by 2 or 4 pixel steps, and the fine field contributes its upper bit or both of its bits.
- R5: On `lineStart` the position counter loads (lineHpos × 2) << res. It then increments once per `pixEn` cycle and is compared modulo the fetch size.
- R6: `blockLoad` fills every holding register and sets the pending flags of both groups. In a `pixEn` cycle where a group is pending and the position equals that group's delay, that pixel is the MSB of the new word, and the group's pending flag clears. A loaded word is therefore shown once.
- R7: Each shift register emits its MSB and shifts left by one per `pixEn` cycle. `pixOut` is registered, and it holds its value in cycles where `pixEn` is low.
- R8: A `scrollWr` only stages the control word. The delays change at the next `fetchBoundary`, and not before.
- R9: On `blockLoad`, a plane whose `planeDma` bit is 0 takes the last word it received by DMA in place of `fetchData`.
- R10: A plane whose index is not below `planeCount` outputs 0. The exception is a plane that has been active since the last `lineStart`: it keeps shifting out its data even after `planeCount` drops.
- R11: In every fetch mode, the first pixel of group A is separated from that of group B by exactly the difference of their programmed delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel clock enable: one output bit per plane |
| lineStart | input | 1 | Start of fetching on a line: loads the position counter |
| lineHpos | input | 9 | Horizontal position at which fetching starts |
| blockLoad | input | 1 | A complete block of plane words is on `fetchData` |
| fetchData | input | 512 | Fetched words, 64 bits per plane, plane 0 in the low bits |
| planeDma | input | 8 | Per-plane flag: this plane's word was fetched by DMA |
| planeCount | input | 4 | Number of active planes (0 to 8) |
| resCode | input | 2 | Resolution code: 0 low, 1 high, 2 super-high |
| fetchMode | input | 2 | Fetch width code: 0 = 16, 1 = 32, 2 = 64 bits |
| scrollWr | input | 1 | Write strobe for the scroll control word |
| scrollCtl | input | 16 | Scroll control word |
| fetchBoundary | input | 1 | Fetch-cycle boundary: staged control becomes live |
| pixOut | output | 8 | One pixel bit per plane |

## Verification
The hardest case to reach is the one where the delay decoding must line up with the position counter's wrap-around: either a delay lies below the start position, or a group's delay sits near the top of a 64-bit fetch window. The bench reaches it by starting a line at a non-zero horizontal position, and by running each fetch mode for two full windows. It puts a single marker bit at the fetch MSB of one plane in each group. The index at which each marker appears then shows the effective delay directly, and the count of markers shows that the pending flag cleared.

// File: rtl/bpl_scroll_pkg.sv
package bpl_scroll_pkg;

  // Highest resolution code; the fine field is shifted right by (RES_MAX - res)
  localparam int RES_MAX = 2;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;      // advance every shift register by one pixel
    logic loadHold;     // capture a complete block into the holding registers
    logic lineRestart;  // new line: re-evaluate the shown-plane set
    logic copyA;        // group A (even indices) holding -> shifter
    logic copyB;        // group B (odd indices) holding -> shifter
  } scrollStrb_t;

endpackage

// File: rtl/bpl_scroll_ctrl.sv
module bpl_scroll_ctrl
  import bpl_scroll_pkg::*;
#(
  parameter int FM_MAX = 2,
  parameter int HPOS_W = 9,
  localparam int POS_W = 4 + FM_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixEn,
  input  logic              lineStart,
  input  logic [HPOS_W-1:0] lineHpos,
  input  logic              blockLoad,
  input  logic [1:0]        resCode,
  input  logic [1:0]        fetchMode,
  input  logic              scrollWr,
  input  logic [15:0]       scrollCtl,
  input  logic              fetchBoundary,
  output scrollStrb_t       strb,
  output logic [POS_W-1:0]  fetchMask,
  output logic [POS_W-1:0]  delayA,
  output logic [POS_W-1:0]  delayB
);

  logic [15:0]      ctlLive;
  logic [15:0]      ctlStaged;
  logic             stagedValid;
  logic [POS_W-1:0] posCnt;
  logic [1:0]       pending;
  logic [1:0]       copyHit;
  logic [1:0]       resEff;
  logic [1:0]       fmEff;
  logic [POS_W-1:0] grpDelay [2];

  // Clamp out-of-range mode codes to the largest supported value
  assign resEff = (resCode > 2'(RES_MAX)) ? 2'(RES_MAX) : resCode;
  assign fmEff  = (fetchMode > 2'(FM_MAX)) ? 2'(FM_MAX) : fetchMode;
  assign fetchMask = POS_W'((32'd16 << fmEff) - 32'd1);

  // Control word: a write stages it, a boundary makes it live
  always_ff @(posedge clk) begin
    if (rst) begin
      ctlLive     <= '0;
      ctlStaged   <= '0;
      stagedValid <= 1'b0;
    end else begin
      if (fetchBoundary && stagedValid) begin
        ctlLive     <= ctlStaged;
        stagedValid <= 1'b0;
      end
      if (scrollWr) begin
        ctlStaged   <= scrollCtl;
        stagedValid <= 1'b1;
      end
    end
  end

  // Per-group delay decode
  for (genvar g = 0; g < 2; g++) begin : gGroup
    logic [5:0] coarse;
    logic [1:0] fine;
    if (g == 0) begin : gA
      assign coarse = {ctlLive[11:10], ctlLive[3:0]};
      assign fine   = ctlLive[13:12];
    end else begin : gB
      assign coarse = {ctlLive[15:14], ctlLive[7:4]};
      assign fine   = ctlLive[9:8];
    end
    always_comb begin
      int unsigned coarsePart;
      int unsigned finePart;
      coarsePart  = (32'(coarse) & (32'(fetchMask) >> resEff)) << resEff;
      finePart    = 32'(fine) >> (RES_MAX - int'(resEff));
      grpDelay[g] = POS_W'(coarsePart | finePart);
    end
    assign copyHit[g] = pixEn && pending[g] && ((posCnt & fetchMask) == grpDelay[g]);
  end

  assign delayA = grpDelay[0];
  assign delayB = grpDelay[1];

  // Delay position counter
  always_ff @(posedge clk) begin
    if (rst) begin
      posCnt <= '0;
    end else if (lineStart) begin
      posCnt <= POS_W'((32'(lineHpos) << 1) << resEff);
    end else if (pixEn) begin
      posCnt <= posCnt + 1'b1;
    end
  end

  // Pending flags: set by a block load, cleared by the group's copy
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (copyHit[g]) pending[g] <= 1'b0;
        if (blockLoad)  pending[g] <= 1'b1;
      end
    end
  end

  assign strb.shiftEn     = pixEn;
  assign strb.loadHold    = blockLoad;
  assign strb.lineRestart = lineStart;
  assign strb.copyA       = copyHit[0];
  assign strb.copyB       = copyHit[1];

endmodule

// File: rtl/bpl_scroll_datapath.sv
module bpl_scroll_datapath
  import bpl_scroll_pkg::*;
#(
  parameter int NUM_PLANES = 8,
  parameter int WORD_W     = 64,
  localparam int IDX_W     = $clog2(WORD_W),
  localparam int CNT_W     = $clog2(NUM_PLANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  scrollStrb_t                  strb,
  input  logic [IDX_W-1:0]             fetchMsb,
  input  logic [NUM_PLANES*WORD_W-1:0] fetchData,
  input  logic [NUM_PLANES-1:0]        planeDma,
  input  logic [CNT_W-1:0]             planeCount,
  output logic [NUM_PLANES-1:0]        pixOut
);

  logic [NUM_PLANES-1:0] countMask;
  logic [NUM_PLANES-1:0] shown;

  always_comb begin
    for (int i = 0; i < NUM_PLANES; i++) begin
      countMask[i] = (32'(planeCount) > i);
    end
  end

  // Planes active at any point of the current line keep draining
  always_ff @(posedge clk) begin
    if (rst) begin
      shown <= '0;
    end else if (strb.lineRestart) begin
      shown <= countMask;
    end else begin
      shown <= shown | countMask;
    end
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : gPlane
    logic [WORD_W-1:0] dataReg;
    logic [WORD_W-1:0] holdReg;
    logic [WORD_W-1:0] shiftReg;
    logic [WORD_W-1:0] srcWord;
    logic              copyMine;
    logic              showMe;
    logic              outBit;

    if ((p % 2) == 1) begin : gOdd
      assign copyMine = strb.copyB;
    end else begin : gEven
      assign copyMine = strb.copyA;
    end

    assign srcWord = copyMine ? holdReg : shiftReg;
    assign showMe  = shown[p] | countMask[p];

    always_ff @(posedge clk) begin
      if (rst) begin
        dataReg  <= '0;
        holdReg  <= '0;
        shiftReg <= '0;
        outBit   <= 1'b0;
      end else begin
        if (strb.loadHold) begin
          if (planeDma[p]) begin
            holdReg <= fetchData[p*WORD_W +: WORD_W];
            dataReg <= fetchData[p*WORD_W +: WORD_W];
          end else begin
            holdReg <= dataReg;
          end
        end
        if (strb.shiftEn) begin
          shiftReg <= srcWord << 1;
          outBit   <= srcWord[fetchMsb] & showMe;
        end
      end
    end

    assign pixOut[p] = outBit;
  end

endmodule

// File: rtl/bpl_scroll_shifter.sv
module bpl_scroll_shifter
  import bpl_scroll_pkg::*;
#(
  parameter int NUM_PLANES = 8,
  parameter int FM_MAX     = 2,
  parameter int HPOS_W     = 9,
  localparam int WORD_W    = 16 << FM_MAX,
  localparam int POS_W     = 4 + FM_MAX,
  localparam int CNT_W     = $clog2(NUM_PLANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pixEn,
  input  logic                         lineStart,
  input  logic [HPOS_W-1:0]            lineHpos,
  input  logic                         blockLoad,
  input  logic [NUM_PLANES*WORD_W-1:0] fetchData,
  input  logic [NUM_PLANES-1:0]        planeDma,
  input  logic [CNT_W-1:0]             planeCount,
  input  logic [1:0]                   resCode,
  input  logic [1:0]                   fetchMode,
  input  logic                         scrollWr,
  input  logic [15:0]                  scrollCtl,
  input  logic                         fetchBoundary,
  output logic [NUM_PLANES-1:0]        pixOut
);

  scrollStrb_t      ctlStrb;
  logic [POS_W-1:0] fetchMask;
  logic [POS_W-1:0] delayA;
  logic [POS_W-1:0] delayB;

  bpl_scroll_ctrl #(
    .FM_MAX (FM_MAX),
    .HPOS_W (HPOS_W)
  ) uCtrl (
    .clk           (clk),
    .rst           (rst),
    .pixEn         (pixEn),
    .lineStart     (lineStart),
    .lineHpos      (lineHpos),
    .blockLoad     (blockLoad),
    .resCode       (resCode),
    .fetchMode     (fetchMode),
    .scrollWr      (scrollWr),
    .scrollCtl     (scrollCtl),
    .fetchBoundary (fetchBoundary),
    .strb          (ctlStrb),
    .fetchMask     (fetchMask),
    .delayA        (delayA),
    .delayB        (delayB)
  );

  bpl_scroll_datapath #(
    .NUM_PLANES (NUM_PLANES),
    .WORD_W     (WORD_W)
  ) uPath (
    .clk        (clk),
    .rst        (rst),
    .strb       (ctlStrb),
    .fetchMsb   (fetchMask),
    .fetchData  (fetchData),
    .planeDma   (planeDma),
    .planeCount (planeCount),
    .pixOut     (pixOut)
  );

endmodule

// File: rtl/bpl_scroll_checker.sv
module bpl_scroll_checker
  import bpl_scroll_pkg::*;
#(
  parameter int NUM_PLANES = 8,
  parameter int POS_W      = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pixEn,
  input logic                  blockLoad,
  input logic                  fetchBoundary,
  input logic [1:0]            resCode,
  input logic [1:0]            fetchMode,
  input logic [NUM_PLANES-1:0] pixOut,
  input scrollStrb_t           strb,
  input logic [POS_W-1:0]      delayA,
  input logic [POS_W-1:0]      delayB
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (pixOut == '0)); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(pixOut)); // R7

  AST_DELAY_A_HELD: assert property (@(posedge clk) disable iff (rst)
    !fetchBoundary |=> (!$stable(resCode) || !$stable(fetchMode) || $stable(delayA))); // R8

  AST_DELAY_B_HELD: assert property (@(posedge clk) disable iff (rst)
    !fetchBoundary |=> (!$stable(resCode) || !$stable(fetchMode) || $stable(delayB))); // R8

  AST_SINGLE_COPY_A: assert property (@(posedge clk) disable iff (rst)
    (strb.copyA && !blockLoad) |=> !strb.copyA); // R6

  AST_SINGLE_COPY_B: assert property (@(posedge clk) disable iff (rst)
    (strb.copyB && !blockLoad) |=> !strb.copyB); // R6

endmodule

bind bpl_scroll_shifter bpl_scroll_checker #(
  .NUM_PLANES (NUM_PLANES),
  .POS_W      (POS_W)
) uChk (
  .clk           (clk),
  .rst           (rst),
  .pixEn         (pixEn),
  .blockLoad     (blockLoad),
  .fetchBoundary (fetchBoundary),
  .resCode       (resCode),
  .fetchMode     (fetchMode),
  .pixOut        (pixOut),
  .strb          (ctlStrb),
  .delayA        (delayA),
  .delayB        (delayB)
);

// File: tb/sim_bpl_scroll_shifter.sv
`timescale 1ns/1ps
module sim_bpl_scroll_shifter;

  logic         clk = 1'b0;
  logic         rst;
  logic         pixEn;
  logic         lineStart;
  logic [8:0]   lineHpos;
  logic         blockLoad;
  logic [511:0] fetchData;
  logic [7:0]   planeDma;
  logic [3:0]   planeCount;
  logic [1:0]   resCode;
  logic [1:0]   fetchMode;
  logic         scrollWr;
  logic [15:0]  scrollCtl;
  logic         fetchBoundary;
  logic [7:0]   pixOut;

  int checks = 0;
  int errors = 0;
  int firstHit [8];
  int hits [8];
  bit done = 0;

  always #2.5 clk = ~clk;

  bpl_scroll_shifter u0 (
    .clk(clk), .rst(rst), .pixEn(pixEn), .lineStart(lineStart), .lineHpos(lineHpos),
    .blockLoad(blockLoad), .fetchData(fetchData), .planeDma(planeDma),
    .planeCount(planeCount), .resCode(resCode), .fetchMode(fetchMode),
    .scrollWr(scrollWr), .scrollCtl(scrollCtl), .fetchBoundary(fetchBoundary),
    .pixOut(pixOut)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; pixEn = 0; lineStart = 0; lineHpos = '0; blockLoad = 0;
    fetchData = '0; planeDma = '1; planeCount = 4'd4; resCode = 0; fetchMode = 0;
    scrollWr = 0; scrollCtl = '0; fetchBoundary = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic setCtl(input logic [15:0] v);
    scrollWr = 1; scrollCtl = v; tick();
    scrollWr = 0; fetchBoundary = 1; tick();
    fetchBoundary = 0;
  endtask

  task automatic startLine(input int h);
    lineStart = 1; lineHpos = 9'(h); tick();
    lineStart = 0;
  endtask

  task automatic loadBlock(input logic [63:0] w0, input logic [63:0] w1,
                           input logic [63:0] w2, input logic [63:0] w3,
                           input logic [7:0] dma);
    fetchData = '0;
    fetchData[0 +: 64]   = w0;
    fetchData[64 +: 64]  = w1;
    fetchData[128 +: 64] = w2;
    fetchData[192 +: 64] = w3;
    planeDma = dma; blockLoad = 1; tick();
    blockLoad = 0; fetchData = '0;
  endtask

  task automatic runPixels(input int n);
    for (int p = 0; p < 8; p++) begin firstHit[p] = -1; hits[p] = 0; end
    pixEn = 1;
    for (int k = 0; k < n; k++) begin
      tick();
      for (int p = 0; p < 8; p++) begin
        if (pixOut[p]) begin
          if (firstHit[p] < 0) firstHit[p] = k;
          hits[p]++;
        end
      end
    end
    pixEn = 0;
  endtask

  // Markers at the fetch MSB on planes 0..3; check group offsets
  task automatic t_mode(input logic [1:0] fm, input logic [1:0] res, input logic [15:0] ctl,
                        input int expA, input int expB, input string tag);
    logic [63:0] mark;
    int size;
    size = 16 << fm;
    mark = 64'd1 << (size - 1);
    fetchMode = fm; resCode = res; planeCount = 4;
    setCtl(ctl);
    startLine(0);
    loadBlock(mark, mark, mark, mark, 8'hFF);
    runPixels(2 * size);
    chk({tag, " group A first pixel"}, firstHit[0], expA);
    chk({tag, " group B first pixel"}, firstHit[1], expB);
    chk({tag, " group A plane 2 first pixel"}, firstHit[2], expA);
    chk({tag, " R6 single showing"}, hits[0] + hits[1], 2);
    chk({tag, " R11 group offset"}, firstHit[1] - firstHit[0], expB - expA);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 pixOut after reset", pixOut, 0);
  endtask

  task automatic t_lineInit();
    // hpos 3, res 0 -> position 6; A=8 -> pixel 2, B=2 wraps -> pixel 12
    fetchMode = 0; resCode = 0; planeCount = 2;
    setCtl(16'h0028);
    startLine(3);
    loadBlock(64'h8000, 64'h8000, 0, 0, 8'hFF);
    runPixels(32);
    chk("R5 start position, group A", firstHit[0], 2);
    chk("R5 wrap modulo fetch size, group B", firstHit[1], 12);
  endtask

  task automatic t_staged();
    fetchMode = 0; resCode = 0; planeCount = 1;
    setCtl(16'h0033);
    scrollWr = 1; scrollCtl = 16'h0099; tick(); scrollWr = 0;
    startLine(0);
    loadBlock(64'h8000, 0, 0, 0, 8'hFF);
    runPixels(32);
    chk("R8 write without boundary keeps old delay", firstHit[0], 3);
    fetchBoundary = 1; tick(); fetchBoundary = 0;
    startLine(0);
    loadBlock(64'h8000, 0, 0, 0, 8'hFF);
    runPixels(32);
    chk("R8 boundary applies staged delay", firstHit[0], 9);
  endtask

  task automatic t_shiftOrder();
    fetchMode = 0; resCode = 0; planeCount = 1;
    setCtl(16'h0000);
    startLine(0);
    loadBlock(64'hA000, 0, 0, 0, 8'hFF);
    runPixels(1);
    chk("R7 MSB first", pixOut[0], 1);
    tick(); tick(); tick();
    chk("R7 output held while pixEn low", pixOut[0], 1);
    runPixels(15);
    chk("R7 next set bit after one zero", firstHit[0], 1);
    chk("R7 bit count of word", hits[0], 1);
  endtask

  task automatic t_reuse();
    fetchMode = 0; resCode = 0; planeCount = 2;
    setCtl(16'h0000);
    startLine(0);
    loadBlock(64'h8000, 64'h8000, 0, 0, 8'hFF);
    runPixels(16);
    chk("R9 first block plane 0", firstHit[0], 0);
    loadBlock(0, 0, 0, 0, 8'hFE);
    runPixels(16);
    chk("R9 plane without DMA reuses last word", firstHit[0], 0);
    chk("R9 plane with DMA takes new zero word", hits[1], 0);
  endtask

  task automatic t_planes();
    fetchMode = 0; resCode = 0;
    setCtl(16'h0062);
    planeCount = 1;
    startLine(0);
    loadBlock(64'h8000, 64'h8000, 0, 0, 8'hFF);
    runPixels(16);
    chk("R10 plane beyond count silent", hits[1], 0);
    chk("R10 plane within count shown", firstHit[0], 2);
    planeCount = 2;
    startLine(0);
    loadBlock(64'h8000, 64'h8000, 0, 0, 8'hFF);
    planeCount = 1;
    runPixels(16);
    chk("R10 plane keeps draining after count drops", firstHit[1], 6);
  endtask

  initial begin
    t_reset();
    t_mode(2'd0, 2'd0, 16'h0053, 3, 5, "R2 low res 16-bit");
    t_mode(2'd0, 2'd0, 16'h0C02, 2, 0, "R3 coarse upper bits masked at 16-bit");
    t_mode(2'd1, 2'd0, 16'h4421, 17, 18, "R3 32-bit fetch");
    t_mode(2'd2, 2'd0, 16'h8C05, 53, 32, "R3 64-bit fetch");
    t_mode(2'd0, 2'd1, 16'h2143, 7, 8, "R4 high res");
    t_mode(2'd0, 2'd2, 16'h3002, 11, 0, "R4 super-high res");
    t_lineInit();
    t_staged();
    t_shiftOrder();
    t_reuse();
    t_planes();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule